// File: doc/BRIEF.md
# Hamming single-error corrector

This block repairs a 12-bit Hamming codeword that carries 8 data bits and 4 check bits. On a valid strobe it recomputes every check bit over the positions it protects and forms a 4-bit syndrome. When exactly one bit has flipped, the syndrome is the binary index of that bit. A one-hot position decoder turns the syndrome into a flip mask for the eight data positions. The corrected byte, the syndrome and an error flag are registered and appear one clock later, together with an output valid.

A purely combinational companion encoder sits beside the decoder. It builds the 12-bit codeword from a byte so that the transmit side of a link can share the same position map. Widths are parameters. The number of check bits is derived as the smallest p with 2^p >= m + p + 1. Double-error detection is not offered. A double error whose syndrome lands on a data position is miscorrected.

Top module: `ham_sec_top`

## Requirements
- R1: Codeword bit `[p-1]` holds position p (p = 1..12). Check bits sit at positions 1, 2, 4 and 8. Data bits d0..d7, from LSB up, sit at positions 3, 5, 6, 7, 9, 10, 11 and 12 in ascending order. The encoder output follows this map.
- R2: Each check bit at position 2^k gives even parity over every position whose index has bit k set, the check position included. The encoder output therefore has all-zero syndrome.
- R3: The syndrome output is the XOR of the indices of all set positions. For a single flipped bit at position p of a valid codeword, this equals p.
- R4: A zero syndrome passes the received data bits through unchanged, with the error flag low.
- R5: A syndrome naming a data position inverts exactly that data bit and raises the error flag. Any single-bit error in a data position is therefore corrected.
- R6: A syndrome naming a check-bit position (1, 2, 4 or 8) leaves the data unchanged and raises the error flag.
- R7: A syndrome above 12 (13, 14 or 15) leaves the data unchanged and raises the error flag.
- R8: The outputs update on the clock edge that samples the valid strobe high, and the output valid is high in that same cycle only. Without a strobe, data, syndrome and flag hold their values.
- R9: While reset is active, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Codeword strobe |
| codeword_i | input | 12 | Received codeword, bit [p-1] is position p |
| enc_data_i | input | 8 | Byte to encode |
| enc_word_o | output | 12 | Encoded codeword (combinational) |
| valid_o | output | 1 | Registered outputs are new this cycle |
| data_o | output | 8 | Corrected data |
| syndrome_o | output | 4 | Registered syndrome |
| err_o | output | 1 | Non-zero syndrome |

## Verification
A wrong coverage mask in the syndrome logic shows up one cycle after the strobe. The syndrome for some single-bit flip no longer equals the flipped position, and the repaired byte differs from the sent byte. A decoder that maps the syndrome to the wrong data index shows up in the same cycle, as one bit repaired while a different bit stays corrupted. The bench therefore sweeps every single-bit position for several bytes, and also drives out-of-range syndromes and idle cycles. Each cycle it compares all four registered outputs against a behavioural model.

// File: rtl/ham_pkg.sv
package ham_pkg;
  localparam int MAX_W = 64;

  function automatic int chk_bits(input int m);
    int p;
    p = 0;
    while ((1 << p) < m + p + 1) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // position (1-based) of data bit j
  function automatic int data_pos(input int j);
    int r;
    int n;
    r = 0;
    n = 0;
    for (int p = 1; p < MAX_W; p++) begin
      if (!is_pow2(p)) begin
        if (n == j && r == 0) r = p;
        n++;
      end
    end
    return r;
  endfunction

  // positions 1..w whose index has bit k set
  function automatic logic [MAX_W-1:0] cover_mask(input int k, input int w);
    logic [MAX_W-1:0] m;
    m = '0;
    for (int p = 1; p <= w; p++) begin
      if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ham_encoder.sv
module ham_encoder #(
  parameter int DATA_W = 8,
  localparam int CHK_W = ham_pkg::chk_bits(DATA_W),
  localparam int CW_W  = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   word_o
);
  import ham_pkg::*;

  logic [CW_W-1:0]  base;
  logic [CHK_W-1:0] chk;

  always_comb begin
    base = '0;
    for (int j = 0; j < DATA_W; j++) base[data_pos(j)-1] = data_i[j];
  end

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [MAX_W-1:0] COVER = cover_mask(k, CW_W);
    assign chk[k] = ^(base & COVER[CW_W-1:0]);
  end

  always_comb begin
    word_o = base;
    for (int k = 0; k < CHK_W; k++) word_o[(1 << k) - 1] = chk[k];
  end
endmodule

// File: rtl/ham_syndrome.sv
module ham_syndrome #(
  parameter int CW_W  = 12,
  parameter int CHK_W = 4
) (
  input  logic [CW_W-1:0]  cw_i,
  output logic [CHK_W-1:0] syn_o
);
  import ham_pkg::*;

  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    localparam logic [MAX_W-1:0] COVER = cover_mask(k, CW_W);
    assign syn_o[k] = ^(cw_i & COVER[CW_W-1:0]);
  end
endmodule

// File: rtl/ham_pos_decoder.sv
module ham_pos_decoder #(
  parameter int DATA_W = 8,
  parameter int CW_W   = 12,
  parameter int CHK_W  = 4
) (
  input  logic [CHK_W-1:0]  syn_i,
  output logic [DATA_W-1:0] flip_o
);
  import ham_pkg::*;

  logic [CW_W-1:0] hot;

  for (genvar p = 1; p <= CW_W; p++) begin : g_hot
    assign hot[p-1] = (syn_i == CHK_W'(p));
  end

  // only data positions drive the mask; check-bit outputs stay unused
  for (genvar j = 0; j < DATA_W; j++) begin : g_flip
    assign flip_o[j] = hot[data_pos(j)-1];
  end

  always_comb begin
    a_r3_hot_onehot: assert ($onehot0(hot));
    a_r5_single_flip: assert ($countones(flip_o) <= 1);
  end

  logic unused_hot;
  always_comb begin
    unused_hot = 1'b0;
    for (int k = 0; k < CHK_W; k++) unused_hot = unused_hot ^ hot[(1 << k) - 1];
  end
endmodule

// File: rtl/ham_sec_top.sv
module ham_sec_top #(
  parameter int DATA_W = 8,
  localparam int CHK_W = ham_pkg::chk_bits(DATA_W),
  localparam int CW_W  = DATA_W + CHK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CW_W-1:0]   codeword_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CW_W-1:0]   enc_word_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  syndrome_o,
  output logic              err_o
);
  import ham_pkg::*;

  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] flip;
  logic [DATA_W-1:0] rx_data;

  ham_encoder #(.DATA_W(DATA_W)) u_enc (
    .data_i (enc_data_i),
    .word_o (enc_word_o)
  );

  ham_syndrome #(.CW_W(CW_W), .CHK_W(CHK_W)) u_syn (
    .cw_i  (codeword_i),
    .syn_o (syn)
  );

  ham_pos_decoder #(.DATA_W(DATA_W), .CW_W(CW_W), .CHK_W(CHK_W)) u_dec (
    .syn_i  (syn),
    .flip_o (flip)
  );

  for (genvar j = 0; j < DATA_W; j++) begin : g_rx
    assign rx_data[j] = codeword_i[data_pos(j)-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      data_o     <= '0;
      syndrome_o <= '0;
      err_o      <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o     <= rx_data ^ flip;
        syndrome_o <= syn;
        err_o      <= (syn != '0);
      end
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r8_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(data_o) && $stable(syndrome_o) && $stable(err_o)));
  a_r4_clean_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (syn == '0) |=> (data_o == $past(rx_data)) && !err_o);
  a_r5_at_most_one_fix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> $countones(data_o ^ $past(rx_data)) <= 1);
  a_r7_flag_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (err_o == (syndrome_o != '0)));
endmodule

// File: tb/ham_sec_top_tb_top.sv
module ham_sec_top_tb_top;
  localparam int DW = 8;
  localparam int CW = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic vld = 0;
  logic [CW-1:0] cw = '0;
  logic [DW-1:0] enc_d = '0;
  logic [CW-1:0] enc_w;
  logic vld_o;
  logic [DW-1:0] d_o;
  logic [3:0] s_o;
  logic e_o;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] x_data = '0;
  logic [3:0]    x_syn = '0;
  logic          x_err = 0;

  always #4 clk = ~clk;

  ham_sec_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .codeword_i(cw),
    .enc_data_i(enc_d), .enc_word_o(enc_w), .valid_o(vld_o),
    .data_o(d_o), .syndrome_o(s_o), .err_o(e_o)
  );

  function automatic int dpos(int j);
    int n = 0;
    int r = 0;
    for (int p = 1; p <= CW; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8) begin
        if (n == j) r = p;
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [3:0] rsyn(logic [CW-1:0] w);
    int s = 0;
    for (int p = 1; p <= CW; p++) if (w[p-1]) s = s ^ p;
    return 4'(s);
  endfunction

  function automatic logic [DW-1:0] rdata(logic [CW-1:0] w);
    logic [DW-1:0] d;
    for (int j = 0; j < DW; j++) d[j] = w[dpos(j)-1];
    return d;
  endfunction

  function automatic logic [CW-1:0] renc(logic [DW-1:0] d);
    logic [CW-1:0] w = '0;
    logic [3:0] s;
    for (int j = 0; j < DW; j++) w[dpos(j)-1] = d[j];
    s = rsyn(w);
    w[0] = s[0]; w[1] = s[1]; w[3] = s[2]; w[7] = s[3];
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle and compare registered outputs after the edge
  task automatic step(logic v, logic [CW-1:0] w, string tag);
    logic [3:0] s;
    logic [DW-1:0] d;
    @(negedge clk);
    vld = v;
    cw = w;
    if (v) begin
      s = rsyn(w);
      d = rdata(w);
      for (int j = 0; j < DW; j++) if (int'(s) == dpos(j)) d[j] = ~d[j];
      x_data = d;
      x_syn = s;
      x_err = (s != 0);
    end
    @(posedge clk);
    #1;
    chk({tag, " R8 valid_o"}, 32'(vld_o), 32'(v));
    chk({tag, " data"}, 32'(d_o), 32'(x_data));
    chk({tag, " R3 syndrome"}, 32'(s_o), 32'(x_syn));
    chk({tag, " err"}, 32'(e_o), 32'(x_err));
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
    logic [CW-1:0] g;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset valid", 32'(vld_o), 0);
    chk("R9 reset data", 32'(d_o), 0);
    chk("R9 reset syn", 32'(s_o), 0);
    chk("R9 reset err", 32'(e_o), 0);
    @(negedge clk);
    rst_n = 1;

    foreach (pats[i]) begin
      @(negedge clk);
      enc_d = pats[i];
      #1;
      chk("R1 R2 encoder word", 32'(enc_w), 32'(renc(pats[i])));
      chk("R1 d0 at position 3", 32'(enc_w[2]), 32'(pats[i][0]));
      chk("R1 d7 at position 12", 32'(enc_w[11]), 32'(pats[i][7]));
      chk("R2 encoder zero syndrome", 32'(rsyn(enc_w)), 0);
      g = renc(pats[i]);
      step(1, g, "R4 clean");
      chk("R4 clean data", 32'(d_o), 32'(pats[i]));
      for (int p = 1; p <= CW; p++) begin
        step(1, g ^ (12'd1 << (p - 1)), "R5 R6 single flip");
        chk("R3 syndrome is position", 32'(s_o), 32'(p));
        chk("R5 R6 data repaired", 32'(d_o), 32'(pats[i]));
        chk("R5 R6 err high", 32'(e_o), 1);
      end
    end

    g = renc(8'h5A);
    step(1, g ^ 12'h090, "R7 syn13");
    chk("R7 syn 13", 32'(s_o), 13);
    chk("R7 data unrepaired", 32'(d_o), 32'(rdata(g ^ 12'h090)));
    step(1, g ^ 12'h0A0, "R7 syn14");
    chk("R7 syn 14", 32'(s_o), 14);
    step(1, g ^ 12'h0C0, "R7 syn15");
    chk("R7 syn 15", 32'(s_o), 15);
    chk("R7 err", 32'(e_o), 1);

    step(1, renc(8'hC3) ^ 12'h020, "R8 load");
    for (int n = 0; n < 4; n++) step(0, 12'hFFF - 12'(n), "R8 idle hold");
    chk("R8 held data", 32'(d_o), 32'hC3);
    step(1, renc(8'h11), "R8 reload");
    step(0, '0, "R8 idle");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule